// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Core

This block is the digital heart of a two-channel, 12-bit, voltage-output converter. A host sends 16-bit command words over a three-wire serial port made of a chip select, a serial clock and a data line. The block samples these pins with a fast system clock and collects the bits. It runs the decoded command when chip select rises. Each channel has two registers in series: a staging (input) register and a live (DAC) register. The live register's value is the code handed to the analog converter. Commands can stage a value, stage and go live, move both staged values live at once, or load every register in one word.

A command prefix of zero opens a sub-command field. This field requests live updates from the staged values, puts channels to sleep, drives a general-purpose output pin, or picks the serial clock edge on which the shift register's top bit is driven out for daisy-chaining. A sleep-enable input blocks sleep while it is low. When it falls, it wakes any sleeping channel at once, with its previous code intact. A wipe input clears every staged and live register to zero.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame is 16 bits, most significant first: a 3-bit prefix in bits 15..13, twelve data bits in bits 12..1 and a trailing zero bit 0. Bits shift in on a rising serial clock only while chip select is low. No register changes until chip select rises.
- R2: Prefix 001 stages the data into channel A, and prefix 101 stages it into channel B. Neither changes any live code.
- R3: Prefix 010 stages the data into A and prefix 110 stages it into B. In both cases both live registers then take their staged values, the new one included.
- R4: Prefix 111 writes the data into both staged and both live registers.
- R5: With prefix 000, data bits 11..9 select live updates from the staged values: 001 updates both channels, 110 updates A only, 111 updates B only.
- R6: With prefix 000, data bits 11..9 put channels to sleep: 101 both, 010 A, 011 B. Sleep keeps the staged and live values. A channel wakes when its live register is loaded or updated.
- R7: While sd_allow is low, sleep commands are ignored and both sleep flags are held at zero. The live codes are unchanged by this wake.
- R8: With prefix 000, data bits 11..8 = 1001 drive gp_out high and 1000 drive it low.
- R9: With prefix 000, data bits 11..8 = 0001 select edge mode 1, where ser_do follows the shift register's top bit from the rising edge. 0000 selects edge mode 0 (the reset default), where ser_do takes that bit on each falling edge, so a bit appears 16 clocks after it entered. Mode 0 changes nothing else.
- R10: While wipe_n is low, both staged and both live registers are zero.
- R11: A frame with fewer than 16 clocks changes no register. A longer frame acts on the last 16 bits shifted.
- R12: After reset, codes and sleep flags are zero, gp_out is low and edge mode 0 is active.
- R13: Prefixes 011 and 100 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| wipe_n | input | 1 | Active-low clear of staged and live registers |
| sd_allow | input | 1 | Low blocks sleep and wakes sleeping channels |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_di | input | 1 | Serial data in |
| code_a | output | 12 | Live code of channel A |
| code_b | output | 12 | Live code of channel B |
| shdn_a | output | 1 | Channel A asleep |
| shdn_b | output | 1 | Channel B asleep |
| gp_out | output | 1 | General-purpose output set over the link |
| ser_do | output | 1 | Daisy-chain serial data out |

## Verification
A sleep command and the fall of sd_allow can reach the channel registers in the same system clock cycle. The bench causes this by raising chip select at the end of a sleep-both frame and dropping sd_allow on the very same clock. Both pins pass through equal-depth synchronizers, so the two events arrive together. The lockout must win: both sleep flags must read zero afterwards, while the live codes keep their values. A later update-both command must still work normally.

// File: rtl/dac_ctrl_pkg.sv
// Shared types for the dual-channel DAC command core.
// Assumes exactly two channels, indexed A = 0 and B = 1.
package dac_ctrl_pkg;
    localparam int NCH  = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;
    localparam int PFX_W = 3;
    localparam int SUB_W = 4;

    // Per-frame actions produced by the decoder; all zero means "do nothing".
    typedef struct packed {
        logic [NCH-1:0] ld_in;     // stage the frame data into a channel
        logic [NCH-1:0] xfer;      // move staged value into the live register
        logic [NCH-1:0] shdn_set;  // request sleep for a channel
        logic           gp_wr;
        logic           gp_val;
        logic           mode_wr;
        logic           mode_val;  // 1 = drive serial out from rising edge
    } dac_action_t;
endpackage

// File: rtl/pin_sync.sv
// Multi-bit flop chain that brings asynchronous pins into the clk domain.
// Assumes STAGES >= 2 and that each bit is an independent level.
module pin_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift each pin through the chain of synchronizing flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/serial_rx.sv
// Serial front end: detects edges of the synchronized serial clock and chip
// select, shifts data in MSB first, counts clocks, flags a complete frame at
// chip-select rise and drives the daisy-chain output in either edge mode.
// Assumes inputs are already synchronized and the serial clock is at most
// one eighth of clk.
module serial_rx #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               cs_n_s,
    input  logic               sdi_s,
    input  logic               mode1_i,
    output logic [FRAME_W-1:1] payload_o,
    output logic               frame_stb_o,
    output logic               sdo_o
);
    logic               sck_q, cs_q;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sdo_fall_q;
    logic               sck_rise, sck_fall, cs_rise;

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign cs_rise  = cs_n_s & ~cs_q;

    // Edge history, shift register, clock count and frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q       <= 1'b0;
            cs_q        <= 1'b1;
            sh_q        <= '0;
            cnt_q       <= '0;
            frame_stb_o <= 1'b0;
            sdo_fall_q  <= 1'b0;
        end else begin
            sck_q       <= sck_s;
            cs_q        <= cs_n_s;
            frame_stb_o <= cs_rise && (cnt_q == CNT_W'(FRAME_W));
            if (cs_n_s) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                sh_q <= {sh_q[FRAME_W-2:0], sdi_s};
                if (cnt_q != CNT_W'(FRAME_W)) cnt_q <= cnt_q + 1'b1;
            end
            if (!cs_n_s && sck_fall) sdo_fall_q <= sh_q[FRAME_W-1];
        end
    end

    assign payload_o = sh_q[FRAME_W-1:1];
    assign sdo_o     = mode1_i ? sh_q[FRAME_W-1] : sdo_fall_q;

    // R11
    property stb_single_chk_p;
        @(posedge clk) disable iff (!rst_n) frame_stb_o |=> !frame_stb_o;
    endproperty
    stb_single_chk: assert property (stb_single_chk_p);
endmodule

// File: rtl/cmd_decode.sv
// Combinational command decoder: turns the prefix and data of a completed
// frame into per-channel actions and global writes.
// Assumes the payload holds prefix (top 3 bits) and data; the trailing zero bit is dropped.
module cmd_decode
    import dac_ctrl_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W+PFX_W-1:0] payload_i,
    input  logic                    stb_i,
    output logic [DATA_W-1:0]       data_o,
    output dac_action_t             act_o
);
    logic [PFX_W-1:0] pfx;
    logic [SUB_W-1:0] sub;

    assign pfx    = payload_i[DATA_W+PFX_W-1 -: PFX_W];
    assign data_o = payload_i[DATA_W-1:0];
    assign sub    = data_o[DATA_W-1 -: SUB_W];

    // Map prefix and sub-command onto the action record.
    always_comb begin
        act_o = '0;
        if (stb_i) begin
            unique case (pfx)
                3'b001: act_o.ld_in[CH_A] = 1'b1;
                3'b101: act_o.ld_in[CH_B] = 1'b1;
                3'b010: begin act_o.ld_in[CH_A] = 1'b1; act_o.xfer = '1; end
                3'b110: begin act_o.ld_in[CH_B] = 1'b1; act_o.xfer = '1; end
                3'b111: begin act_o.ld_in = '1; act_o.xfer = '1; end
                3'b000: begin
                    unique case (sub[SUB_W-1:1])
                        3'b001: act_o.xfer = '1;
                        3'b110: act_o.xfer[CH_A] = 1'b1;
                        3'b111: act_o.xfer[CH_B] = 1'b1;
                        3'b101: act_o.shdn_set = '1;
                        3'b010: act_o.shdn_set[CH_A] = 1'b1;
                        3'b011: act_o.shdn_set[CH_B] = 1'b1;
                        3'b100: begin act_o.gp_wr = 1'b1; act_o.gp_val = sub[0]; end
                        3'b000: begin act_o.mode_wr = 1'b1; act_o.mode_val = sub[0]; end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/chan_regs.sv
// One channel's staged register, live register and sleep flag.
// Assumes at most one action set per cycle, coming from a single decoded frame.
module chan_regs #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              lockout_i,
    input  logic              ld_in_i,
    input  logic              xfer_i,
    input  logic              shdn_set_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] code_o,
    output logic              shdn_o
);
    logic [DATA_W-1:0] in_q, dac_q, in_next;

    assign in_next = ld_in_i ? data_i : in_q;

    // Staged and live registers; the wipe wins over any frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            in_q <= in_next;
            if (xfer_i) dac_q <= in_next;
        end
    end

    // Sleep flag: lockout and live loads wake, a sleep request sets.
    always_ff @(posedge clk) begin
        if (!rst_n || lockout_i || xfer_i) shdn_o <= 1'b0;
        else if (shdn_set_i)               shdn_o <= 1'b1;
    end

    assign code_o = dac_q;

    // R7
    property lockout_wake_chk_p;
        @(posedge clk) disable iff (!rst_n) lockout_i |=> !shdn_o;
    endproperty
    lockout_wake_chk: assert property (lockout_wake_chk_p);

    // R10
    property wipe_zero_chk_p;
        @(posedge clk) disable iff (!rst_n) clear_i |=> (in_q == '0 && dac_q == '0);
    endproperty
    wipe_zero_chk: assert property (wipe_zero_chk_p);
endmodule

// File: rtl/dual_dac_ctrl.sv
// Top of the dual-channel DAC command core: synchronizes the pins, receives
// frames, decodes them and drives two channel register sets plus the
// general-purpose output and the edge-mode flag.
// Assumes clk runs at least eight times faster than the serial clock.
module dual_dac_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_n,
    input  logic              sd_allow,
    input  logic              ser_cs_n,
    input  logic              ser_clk,
    input  logic              ser_di,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              shdn_a,
    output logic              shdn_b,
    output logic              gp_out,
    output logic              ser_do
);
    localparam int FRAME_W = DATA_W + PFX_W + 1;

    logic [4:0]                pins_s;
    logic                      cs_n_s, wipe_s, allow_s, sck_s, sdi_s;
    logic [FRAME_W-1:1]        payload;
    logic                      frame_stb;
    logic [DATA_W-1:0]         data;
    dac_action_t               act;
    logic                      mode1_q;
    logic [DATA_W-1:0]         code [NCH];
    logic [NCH-1:0]            shdn;

    pin_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_cs_n, wipe_n, sd_allow, ser_clk, ser_di}),
        .q_o   (pins_s)
    );
    assign {cs_n_s, wipe_s, allow_s, sck_s, sdi_s} = pins_s;

    serial_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (sck_s),
        .cs_n_s      (cs_n_s),
        .sdi_s       (sdi_s),
        .mode1_i     (mode1_q),
        .payload_o   (payload),
        .frame_stb_o (frame_stb),
        .sdo_o       (ser_do)
    );

    cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .payload_i (payload),
        .stb_i     (frame_stb),
        .data_o    (data),
        .act_o     (act)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        chan_regs #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (~wipe_s),
            .lockout_i  (~allow_s),
            .ld_in_i    (act.ld_in[ch]),
            .xfer_i     (act.xfer[ch]),
            .shdn_set_i (act.shdn_set[ch]),
            .data_i     (data),
            .code_o     (code[ch]),
            .shdn_o     (shdn[ch])
        );
    end

    // Global flags written by sub-commands: output pin and edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_out  <= 1'b0;
            mode1_q <= 1'b0;
        end else begin
            if (act.gp_wr)   gp_out  <= act.gp_val;
            if (act.mode_wr) mode1_q <= act.mode_val;
        end
    end

    assign code_a = code[CH_A];
    assign code_b = code[CH_B];
    assign shdn_a = shdn[CH_A];
    assign shdn_b = shdn[CH_B];

    // R1
    property code_commit_chk_p;
        @(posedge clk) disable iff (!rst_n)
            ({code_a, code_b} != $past({code_a, code_b})) |-> ($past(frame_stb) || $past(!wipe_s));
    endproperty
    code_commit_chk: assert property (code_commit_chk_p);

    // R8
    property gp_commit_chk_p;
        @(posedge clk) disable iff (!rst_n) (gp_out != $past(gp_out)) |-> $past(frame_stb);
    endproperty
    gp_commit_chk: assert property (gp_commit_chk_p);

    // R6
    property sleep_commit_chk_p;
        @(posedge clk) disable iff (!rst_n) ($rose(shdn_a) || $rose(shdn_b)) |-> $past(frame_stb);
    endproperty
    sleep_commit_chk: assert property (sleep_commit_chk_p);
endmodule

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wipe_n = 1'b1, sd_allow = 1'b1, ser_cs_n = 1'b1, ser_clk = 1'b0, ser_di = 1'b0;
    logic [11:0] code_a, code_b;
    logic shdn_a, shdn_b, gp_out, ser_do;
    logic hi_do, lo_do;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_dac_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wipe_n(wipe_n), .sd_allow(sd_allow),
        .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_di(ser_di),
        .code_a(code_a), .code_b(code_b), .shdn_a(shdn_a), .shdn_b(shdn_b),
        .gp_out(gp_out), .ser_do(ser_do)
    );

    // word[42:27], code_a[26:15], code_b[14:3], {shdn_a, shdn_b, gp_out}[2:0]
    localparam int NV = 22;
    localparam logic [42:0] VEC [NV] = '{
        {3'b001,12'h123,1'b0, 12'h000,12'h000, 3'b000},  // R2
        {3'b101,12'h456,1'b0, 12'h000,12'h000, 3'b000},  // R2
        {3'b000,12'h200,1'b0, 12'h123,12'h456, 3'b000},  // R5 both
        {3'b010,12'h7AA,1'b0, 12'h7AA,12'h456, 3'b000},  // R3
        {3'b101,12'h0F0,1'b0, 12'h7AA,12'h456, 3'b000},  // R2
        {3'b000,12'hE00,1'b0, 12'h7AA,12'h0F0, 3'b000},  // R5 B
        {3'b001,12'h333,1'b0, 12'h7AA,12'h0F0, 3'b000},
        {3'b000,12'hC00,1'b0, 12'h333,12'h0F0, 3'b000},  // R5 A
        {3'b000,12'hA00,1'b0, 12'h333,12'h0F0, 3'b110},  // R6 both
        {3'b001,12'h555,1'b0, 12'h333,12'h0F0, 3'b110},  // R6 staging keeps sleep
        {3'b000,12'hC00,1'b0, 12'h555,12'h0F0, 3'b010},  // R6 wake A
        {3'b000,12'h400,1'b0, 12'h555,12'h0F0, 3'b110},  // R6 A
        {3'b000,12'h600,1'b0, 12'h555,12'h0F0, 3'b110},  // R6 B
        {3'b110,12'h9C3,1'b0, 12'h555,12'h9C3, 3'b000},  // R3
        {3'b000,12'h900,1'b0, 12'h555,12'h9C3, 3'b001},  // R8 high
        {3'b011,12'hFFF,1'b0, 12'h555,12'h9C3, 3'b001},  // R13
        {3'b100,12'hFFF,1'b0, 12'h555,12'h9C3, 3'b001},  // R13
        {3'b111,12'hABC,1'b0, 12'hABC,12'hABC, 3'b001},  // R4
        {3'b000,12'h800,1'b0, 12'hABC,12'hABC, 3'b000},  // R8 low
        {3'b000,12'h000,1'b0, 12'hABC,12'hABC, 3'b000},  // R9 zero word
        {3'b101,12'h111,1'b0, 12'hABC,12'hABC, 3'b000},
        {3'b000,12'h200,1'b0, 12'hABC,12'h111, 3'b000}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] bits, input int n, input bit raise);
        ser_cs_n = 1'b0; tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_di = bits[i]; tick(4);
            ser_clk = 1'b1; tick(4);
            if (i == 0) hi_do = ser_do;
            ser_clk = 1'b0; tick(4);
            if (i == 0) lo_do = ser_do;
        end
        if (raise) begin ser_cs_n = 1'b1; tick(8); end
    endtask

    function automatic logic [31:0] wd(input logic [2:0] p, input logic [11:0] d);
        return {16'h0, p, d, 1'b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5); rst_n = 1'b1; tick(5);
        // R12 reset state
        check("R12 code_a", code_a, 0);
        check("R12 code_b", code_b, 0);
        check("R12 sleep", {shdn_a, shdn_b}, 0);
        check("R12 gp_out", gp_out, 0);

        for (int v = 0; v < NV; v++) begin
            send({16'h0, VEC[v][42:27]}, 16, 1'b1);
            check($sformatf("vec%0d code_a R2/R3/R4/R5", v), code_a, VEC[v][26:15]);
            check($sformatf("vec%0d code_b R2/R3/R4/R5", v), code_b, VEC[v][14:3]);
            check($sformatf("vec%0d flags R6/R8/R13", v), {shdn_a, shdn_b, gp_out}, VEC[v][2:0]);
        end

        // R11 short frame discarded
        send(wd(3'b001, 12'hFFF) >> 6, 10, 1'b1);
        send(wd(3'b000, 12'h200), 16, 1'b1);
        check("R11 short frame", code_a, 12'hABC);
        // R11 long frame keeps last 16 bits
        send({12'h0, 4'hF, wd(3'b001, 12'h0DE)[15:0]}, 20, 1'b1);
        send(wd(3'b000, 12'hC00), 16, 1'b1);
        check("R11 long frame", code_a, 12'h0DE);
        check("R11 long frame B", code_b, 12'h111);

        // R9 edge modes
        send(wd(3'b101, 12'h321), 16, 1'b1);
        check("R9 mode0 before fall", hi_do, 0);
        check("R9 mode0 after fall", lo_do, 1);
        send(wd(3'b000, 12'h100), 16, 1'b1);
        send(wd(3'b101, 12'h321), 16, 1'b1);
        check("R9 mode1 on rise", hi_do, 1);
        send(wd(3'b000, 12'h000), 16, 1'b1);
        send(wd(3'b101, 12'h321), 16, 1'b1);
        check("R9 mode0 restored", hi_do, 0);
        check("R9 mode0 lag", lo_do, 1);
        check("R9 codes untouched", code_b, 12'h111);

        // R7 lockout
        sd_allow = 1'b0; tick(4);
        send(wd(3'b000, 12'hA00), 16, 1'b1);
        check("R7 sleep ignored", {shdn_a, shdn_b}, 0);
        sd_allow = 1'b1; tick(4);
        send(wd(3'b000, 12'hA00), 16, 1'b1);
        check("R6 sleep both", {shdn_a, shdn_b}, 2'b11);
        sd_allow = 1'b0; tick(6);
        check("R7 wake", {shdn_a, shdn_b}, 0);
        check("R7 codes kept", {code_a, code_b}, {12'h0DE, 12'h111});
        sd_allow = 1'b1; tick(4);

        // R7 same-cycle sleep command and lockout fall
        send(wd(3'b000, 12'hA00), 16, 1'b0);
        ser_cs_n = 1'b1; sd_allow = 1'b0; tick(8);
        check("R7 conflict", {shdn_a, shdn_b}, 0);
        sd_allow = 1'b1; tick(4);
        send(wd(3'b000, 12'h200), 16, 1'b1);
        check("R5 after conflict", {code_a, code_b}, {12'h0DE, 12'h321});

        // R1 nothing before chip select rises
        send(wd(3'b111, 12'h5A5), 16, 1'b0);
        tick(8);
        check("R1 held before cs rise", code_a, 12'h0DE);
        ser_cs_n = 1'b1; tick(8);
        check("R1 applied at cs rise", {code_a, code_b}, {12'h5A5, 12'h5A5});

        // R10 wipe
        wipe_n = 1'b0; tick(6); wipe_n = 1'b1; tick(4);
        check("R10 live cleared", {code_a, code_b}, 0);
        send(wd(3'b000, 12'h200), 16, 1'b1);
        check("R10 staged cleared", {code_a, code_b}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule